// File: doc/BRIEF.md
# Over-Temperature ADC Shutdown Guard

This block watches a temperature reading, an unsigned integer in degrees Celsius that arrives with a one-cycle valid strobe whenever a new sample exists. If a sample runs hotter than the trip level while protection is enabled, the guard latches into a protected state. In that state it powers the channel ADCs down and drops the acquisition run signal. Data already captured downstream stays readable, because the guard only gates the enable and run controls.

The latch is released only by a sample at or below a lower release level, or by turning protection off. Samples between the two levels keep the block latched. Leaving protection never turns anything back on by itself. The user must raise the ADC-enable or run request again from low to high. A sticky flag records that a trip happened and stays set until software clears it.

Top module: `thermal_guard`

## Requirements
- R1: After reset, and after any later reset, protActive, adcEnOut, runOut and tripSticky are all 0 on the first sampled cycle.
- R2: A valid sample strictly above TRIP_C (default 70) with protEn high sets protActive and forces adcEnOut and runOut to 0 after the next rising clock edge. A sample equal to TRIP_C does not trip.
- R3: tempIn is ignored in any cycle where tempValid is low.
- R4: While protected, valid samples above RELEASE_C (default 61) keep protActive at 1. This includes samples in the band between the release and trip levels.
- R5: A valid sample at or below RELEASE_C clears protActive after the next edge. adcEnOut and runOut remain 0.
- R6: While protActive is 1, adcEnOut and runOut are 0 and rising edges on the requests are ignored.
- R7: In the normal state, adcEnOut (runOut) becomes 1 on the edge after a low-to-high change of adcEnReq (runReq). A request that is held high across a release does not re-enable the output.
- R8: In the normal state, adcEnOut (runOut) returns to 0 on the edge after its request is low.
- R9: With protEn low, no sample trips the guard. Driving protEn low while protected releases the latch after the next edge.
- R10: tripSticky is set by a trip and holds until stickyClr is high. If a trip and stickyClr occur in the same cycle, the trip wins.
- R11: A trip takes priority over a request rising edge in the same cycle; the outputs go to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| tempIn | input | TEMP_W | Temperature in degrees Celsius, unsigned |
| tempValid | input | 1 | tempIn holds a new sample this cycle |
| adcEnReq | input | 1 | User request to power the ADCs |
| runReq | input | 1 | User request to run acquisition |
| protEn | input | 1 | Enables over-temperature protection |
| stickyClr | input | 1 | Clears tripSticky |
| adcEnOut | output | 1 | ADC power enable (0 = powered down) |
| runOut | output | 1 | Acquisition run state |
| protActive | output | 1 | Protection latched |
| tripSticky | output | 1 | A trip has occurred since the last clear |

## Verification
The bench targets the boundaries of the two thresholds: exactly the trip level, one degree above it, the release level plus one, and the release level itself. A design with an off-by-one comparison would trip too early or release inside the hysteresis band. It also holds a request high across a release. A design that re-armed on the level instead of the edge would power the ADCs back up with no new request. Finally, it collides a trip with a sticky clear and with a request edge in the same cycle, and it drops protEn while latched. A design with the wrong priorities would lose the sticky record, would let the ADCs turn on during a trip, or would stay stuck in protection.

// File: rtl/thermal_guard_pkg.sv
package thermal_guard_pkg;

  typedef enum logic {
    GUARD_NORMAL  = 1'b0,
    GUARD_PROTECT = 1'b1
  } guardState_t;

  // strobes from datapath to control
  typedef struct packed {
    logic tripHit;     // valid sample above trip level
    logic releaseHit;  // valid sample at or below release level
    logic adcRise;     // adcEnReq rising edge
    logic runRise;     // runReq rising edge
    logic adcLow;      // adcEnReq low
    logic runLow;      // runReq low
  } thermStrobe_t;

endpackage

// File: rtl/thermal_guard_datapath.sv
module thermal_guard_datapath
  import thermal_guard_pkg::*;
#(
  parameter int TEMP_W    = 8,
  parameter int TRIP_C    = 70,
  parameter int RELEASE_C = 61
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [TEMP_W-1:0] tempIn,
  input  logic              tempValid,
  input  logic              adcEnReq,
  input  logic              runReq,
  output thermStrobe_t      strobes
);

  localparam logic [TEMP_W-1:0] TripLevel    = TEMP_W'(TRIP_C);
  localparam logic [TEMP_W-1:0] ReleaseLevel = TEMP_W'(RELEASE_C);
  localparam int               NumReq       = 2;

  logic [NumReq-1:0] reqNow;
  logic [NumReq-1:0] reqPrev;
  logic [NumReq-1:0] reqRise;

  assign reqNow = {runReq, adcEnReq};

  always_ff @(posedge clk) begin
    if (!rstN) reqPrev <= '0;
    else       reqPrev <= reqNow;
  end

  for (genvar i = 0; i < NumReq; i++) begin : g_edge
    assign reqRise[i] = reqNow[i] & ~reqPrev[i];
  end

  always_comb begin
    strobes            = '0;
    strobes.tripHit    = tempValid && (tempIn > TripLevel);
    strobes.releaseHit = tempValid && (tempIn <= ReleaseLevel);
    strobes.adcRise    = reqRise[0];
    strobes.runRise    = reqRise[1];
    strobes.adcLow     = ~reqNow[0];
    strobes.runLow     = ~reqNow[1];
  end

endmodule

// File: rtl/thermal_guard_ctrl.sv
module thermal_guard_ctrl
  import thermal_guard_pkg::*;
(
  input  logic         clk,
  input  logic         rstN,
  input  thermStrobe_t strobes,
  input  logic         protEn,
  input  logic         stickyClr,
  output logic         adcEnOut,
  output logic         runOut,
  output logic         protActive,
  output logic         tripSticky
);

  guardState_t state;
  logic        tripNow;

  assign tripNow    = (state == GUARD_NORMAL) && protEn && strobes.tripHit;
  assign protActive = (state == GUARD_PROTECT);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state    <= GUARD_NORMAL;
      adcEnOut <= 1'b0;
      runOut   <= 1'b0;
    end else begin
      unique case (state)
        GUARD_NORMAL: begin
          if (tripNow) begin
            state    <= GUARD_PROTECT;
            adcEnOut <= 1'b0;
            runOut   <= 1'b0;
          end else begin
            if (strobes.adcRise)     adcEnOut <= 1'b1;
            else if (strobes.adcLow) adcEnOut <= 1'b0;
            if (strobes.runRise)     runOut   <= 1'b1;
            else if (strobes.runLow) runOut   <= 1'b0;
          end
        end
        GUARD_PROTECT: begin
          adcEnOut <= 1'b0;
          runOut   <= 1'b0;
          if (!protEn || strobes.releaseHit) state <= GUARD_NORMAL;
        end
        default: state <= GUARD_NORMAL;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN)          tripSticky <= 1'b0;
    else if (tripNow)   tripSticky <= 1'b1;
    else if (stickyClr) tripSticky <= 1'b0;
  end

endmodule

// File: rtl/thermal_guard.sv
module thermal_guard
  import thermal_guard_pkg::*;
#(
  parameter int TEMP_W    = 8,
  parameter int TRIP_C    = 70,
  parameter int RELEASE_C = 61
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [TEMP_W-1:0] tempIn,
  input  logic              tempValid,
  input  logic              adcEnReq,
  input  logic              runReq,
  input  logic              protEn,
  input  logic              stickyClr,
  output logic              adcEnOut,
  output logic              runOut,
  output logic              protActive,
  output logic              tripSticky
);

  thermStrobe_t strobes;

  thermal_guard_datapath #(
    .TEMP_W(TEMP_W), .TRIP_C(TRIP_C), .RELEASE_C(RELEASE_C)
  ) u_dp (
    .clk(clk), .rstN(rstN), .tempIn(tempIn), .tempValid(tempValid),
    .adcEnReq(adcEnReq), .runReq(runReq), .strobes(strobes)
  );

  thermal_guard_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .strobes(strobes), .protEn(protEn),
    .stickyClr(stickyClr), .adcEnOut(adcEnOut), .runOut(runOut),
    .protActive(protActive), .tripSticky(tripSticky)
  );

endmodule

// File: rtl/thermal_guard_chk.sv
module thermal_guard_chk #(
  parameter int TEMP_W    = 8,
  parameter int TRIP_C    = 70,
  parameter int RELEASE_C = 61
) (
  input logic              clk,
  input logic              rstN,
  input logic [TEMP_W-1:0] tempIn,
  input logic              tempValid,
  input logic              adcEnReq,
  input logic              protEn,
  input logic              stickyClr,
  input logic              adcEnOut,
  input logic              runOut,
  input logic              protActive,
  input logic              tripSticky
);

  // R2
  trip_enter_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!protActive && protEn && tempValid && tempIn > TEMP_W'(TRIP_C))
      |=> (protActive && !adcEnOut && !runOut && tripSticky));

  // R6
  prot_outputs_off_chk: assert property (@(posedge clk) disable iff (!rstN)
    protActive |-> (!adcEnOut && !runOut));

  // R4
  hold_band_chk: assert property (@(posedge clk) disable iff (!rstN)
    (protActive && protEn && !(tempValid && tempIn <= TEMP_W'(RELEASE_C)))
      |=> protActive);

  // R3
  no_valid_no_trip_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!protActive && !tempValid) |=> !protActive);

  // R9
  disabled_no_trip_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!protActive && !protEn) |=> !protActive);

  // R10
  sticky_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (tripSticky && !stickyClr) |=> tripSticky);

  // R7
  adc_needs_request_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(adcEnOut) |-> $past(adcEnReq));

endmodule

bind thermal_guard thermal_guard_chk #(
  .TEMP_W(TEMP_W), .TRIP_C(TRIP_C), .RELEASE_C(RELEASE_C)
) u_chk (
  .clk(clk), .rstN(rstN), .tempIn(tempIn), .tempValid(tempValid),
  .adcEnReq(adcEnReq), .protEn(protEn), .stickyClr(stickyClr),
  .adcEnOut(adcEnOut), .runOut(runOut), .protActive(protActive),
  .tripSticky(tripSticky)
);

// File: tb/tb_thermal_guard.sv
`timescale 1ns/1ps
module tb_thermal_guard;

  logic       clk = 1'b0;
  logic       rstN;
  logic [7:0] tempIn;
  logic       tempValid, adcEnReq, runReq, protEn, stickyClr;
  logic       adcEnOut, runOut, protActive, tripSticky;

  int testsRun = 0;
  int testsFailed = 0;
  bit finished = 0;

  always #2 clk = ~clk;

  thermal_guard dut (
    .clk(clk), .rstN(rstN), .tempIn(tempIn), .tempValid(tempValid),
    .adcEnReq(adcEnReq), .runReq(runReq), .protEn(protEn),
    .stickyClr(stickyClr), .adcEnOut(adcEnOut), .runOut(runOut),
    .protActive(protActive), .tripSticky(tripSticky)
  );

  typedef struct packed {
    logic       v;
    logic [7:0] t;
    logic       a;
    logic       r;
    logic       pe;
    logic       clr;
    logic       eProt;
    logic       eAdc;
    logic       eRun;
    logic       eSticky;
  } vec_t;

  localparam int NV = 17;
  localparam vec_t VECS [NV] = '{
    '{1'b0, 8'd25,  1'b1, 1'b0, 1'b1, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0}, // R7 adc rise
    '{1'b1, 8'd25,  1'b1, 1'b1, 1'b1, 1'b0, 1'b0, 1'b1, 1'b1, 1'b0}, // R7 run rise
    '{1'b1, 8'd70,  1'b1, 1'b1, 1'b1, 1'b0, 1'b0, 1'b1, 1'b1, 1'b0}, // R2 equal no trip
    '{1'b0, 8'd90,  1'b1, 1'b1, 1'b1, 1'b0, 1'b0, 1'b1, 1'b1, 1'b0}, // R3 invalid hot
    '{1'b1, 8'd71,  1'b1, 1'b1, 1'b1, 1'b0, 1'b1, 1'b0, 1'b0, 1'b1}, // R2 trip
    '{1'b1, 8'd65,  1'b0, 1'b0, 1'b1, 1'b0, 1'b1, 1'b0, 1'b0, 1'b1}, // R4 band
    '{1'b1, 8'd62,  1'b1, 1'b1, 1'b1, 1'b0, 1'b1, 1'b0, 1'b0, 1'b1}, // R4 R6 edges ignored
    '{1'b1, 8'd61,  1'b1, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1}, // R5 release
    '{1'b0, 8'd61,  1'b1, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1}, // R7 held high
    '{1'b0, 8'd61,  1'b0, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1}, // R8 low
    '{1'b0, 8'd61,  1'b1, 1'b0, 1'b1, 1'b0, 1'b0, 1'b1, 1'b0, 1'b1}, // R7 fresh edge
    '{1'b0, 8'd61,  1'b1, 1'b0, 1'b1, 1'b1, 1'b0, 1'b1, 1'b0, 1'b0}, // R10 clear
    '{1'b1, 8'd100, 1'b1, 1'b1, 1'b1, 1'b1, 1'b1, 1'b0, 1'b0, 1'b1}, // R10 R11 collide
    '{1'b0, 8'd100, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1}, // R9 disable releases
    '{1'b1, 8'd120, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1}, // R9 no trip
    '{1'b1, 8'd120, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0, 1'b1}, // R9 enable while hot
    '{1'b0, 8'd120, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1}  // R8 drop
  };

  task automatic check(input string req, input string what, input logic act, input logic exp);
    testsRun++;
    if (act !== exp) begin
      testsFailed++;
      $display("FAIL %s %s: actual %0b expected %0b", req, what, act, exp);
    end
  endtask

  task automatic idleInputs();
    tempIn = 8'd25; tempValid = 0; adcEnReq = 0; runReq = 0;
    protEn = 1; stickyClr = 0;
  endtask

  task automatic checkAllZero(input string req);
    check(req, "protActive", protActive, 1'b0);
    check(req, "adcEnOut", adcEnOut, 1'b0);
    check(req, "runOut", runOut, 1'b0);
    check(req, "tripSticky", tripSticky, 1'b0);
  endtask

  initial begin
    #200000;
    if (!finished) begin
      testsRun++; testsFailed++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", testsRun, testsFailed);
      $finish;
    end
  end

  initial begin
    idleInputs();
    rstN = 0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rstN = 1;
    checkAllZero("R1");

    for (int i = 0; i < NV; i++) begin
      tempValid = VECS[i].v; tempIn = VECS[i].t;
      adcEnReq = VECS[i].a; runReq = VECS[i].r;
      protEn = VECS[i].pe; stickyClr = VECS[i].clr;
      @(posedge clk);
      @(negedge clk);
      check($sformatf("vec%0d", i), "protActive", protActive, VECS[i].eProt);
      check($sformatf("vec%0d", i), "adcEnOut", adcEnOut, VECS[i].eAdc);
      check($sformatf("vec%0d", i), "runOut", runOut, VECS[i].eRun);
      check($sformatf("vec%0d", i), "tripSticky", tripSticky, VECS[i].eSticky);
    end

    // R1: reset while protected clears everything
    idleInputs();
    tempValid = 1; tempIn = 8'd99;
    @(posedge clk); @(negedge clk);
    check("R2", "protActive pre-reset", protActive, 1'b1);
    tempValid = 0;
    rstN = 0;
    @(posedge clk); @(negedge clk);
    rstN = 1;
    checkAllZero("R1");

    // R5: hot band then release at exactly 61, with requests low
    tempValid = 1; tempIn = 8'd200;
    @(posedge clk); @(negedge clk);
    tempIn = 8'd62;
    @(posedge clk); @(negedge clk);
    check("R4", "protActive at 62", protActive, 1'b1);
    tempValid = 0; tempIn = 8'd10;
    @(posedge clk); @(negedge clk);
    check("R3", "protActive invalid cold", protActive, 1'b1);
    tempValid = 1; tempIn = 8'd61;
    @(posedge clk); @(negedge clk);
    check("R5", "protActive at 61", protActive, 1'b0);
    tempValid = 0; runReq = 1;
    @(posedge clk); @(negedge clk);
    check("R7", "runOut fresh edge", runOut, 1'b1);
    runReq = 0;
    @(posedge clk); @(negedge clk);
    check("R8", "runOut request low", runOut, 1'b0);

    finished = 1;
    $display("[TB] %0d tests run, %0d failed", testsRun, testsFailed);
    $finish;
  end

endmodule